// File: doc/BRIEF.md
# Two-Wire Register Slave with Bus-Lockup Timeout

This block is the serial front end of a small register file. It watches the two-wire serial bus (SCL and SDA) with a fast system clock, answers one fixed 7-bit device address, and turns bus transfers into single-cycle register writes and combinational register reads. It holds a register pointer. The first byte of a write transfer loads that pointer. Each later data byte is written at the pointer, and the pointer then steps up by one. A read transfer streams bytes out from wherever the pointer stands.

For time registers that must be read coherently, the block pulses a snapshot strobe on every START or repeated START, and each time the pointer steps from its top value back to zero. The surrounding logic uses that pulse to copy the live counters into a shadow set, and reads are served from the shadow set. The block only pulls SDA low through an open-drain enable and never holds SCL. If the master leaves SCL low for too long, counted in ticks of a 32.768 kHz enable, the block drops back to idle and lets go of SDA.

The controller states are IDLE, ADDR (shifting the address byte), ACK_ADDR, PTR (shifting the pointer byte), ACK_PTR, WR (shifting a data byte), ACK_WR, RD (sending a byte), ACK_RD (sampling the master's acknowledge) and SKIP (silent until the next START or STOP).

The transitions are as follows:
- A START leads to ADDR from any state.
- A STOP or a timeout leads to IDLE from any state.
- ADDR goes to ACK_ADDR on a matching address and to SKIP on any other address.
- ACK_ADDR goes to RD for a read and to PTR for a write.
- PTR goes to ACK_PTR, then to WR.
- WR and ACK_WR alternate.
- RD goes to ACK_RD. ACK_RD goes back to RD on an ACK and to SKIP on a NACK.

Each move out of a byte state or an ACK state happens on a falling edge of SCL.

Top module: `i2c_regport`

## Requirements
- R1: The address byte is acknowledged when its upper seven bits equal DEV_ADDR (default 7'h68), so 8'hD0 opens a write and 8'hD1 opens a read. The acknowledge pulls SDA low during the ninth clock.
- R2: When the address byte carries any other address, SDA is never driven and no register is written until the next START.
- R3: In a write, the byte after the address loads the pointer from its low ADDR_W bits. Each following byte gives one reg_we pulse lasting one cycle, with reg_addr set to the pointer and reg_wdata set to the byte. The pointer then increases by one.
- R4: The pointer wraps from its highest value (4'hF by default) to 0, in both writes and reads.
- R5: shadow_load pulses for one cycle after every START or repeated START, and after every step of the pointer that lands on 0.
- R6: A read starts at the current pointer, including when no pointer byte came first. Bytes go out MSB first, and the pointer increases by one after each byte.
- R7: After the master NACKs a read byte, SDA stays released until the next START.
- R8: SDA changes only while SCL is low. Received bits are taken on rising SCL edges, and sent bits change after falling edges.
- R9: When SCL stays low for TIMEOUT_TICKS ticks of tick_32k, the block returns to idle and releases SDA, and a byte not yet acknowledged is not written. Any SCL high level restarts the count.
- R10: A START or STOP in the middle of a byte abandons that byte without writing it.
- R11: After reset, SDA is released, reg_we and shadow_load are low, and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_32k | input | 1 | One-cycle enable at 32.768 kHz for the timeout count |
| scl_i | input | 1 | SCL level seen at the pad |
| sda_i | input | 1 | SDA level seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| reg_we | output | 1 | Register write strobe, one cycle |
| reg_addr | output | ADDR_W | Register index for the write or the read |
| reg_wdata | output | 8 | Byte to be written |
| reg_rdata | input | 8 | Byte at reg_addr, combinational from the register file |
| shadow_load | output | 1 | Snapshot strobe for the shadow time registers |

## Verification
The bench builds the block with TIMEOUT_TICKS set to 16 and with tick_32k pulsing every fourth clock. A low SCL therefore times out after about 64 clocks instead of about 30 ms at the true rate. This makes it practical, within a short run, to time out inside a half-received byte and inside a slave acknowledge. It also allows a test where SCL is held low for most of the window twice, with SCL high in between, and the transfer must survive. All other parameters stay at their defaults, so the 16-entry pointer and its wrap from 4'hF to 0 are covered directly by write and read bursts that start at entries 14 and 15.

// File: rtl/i2c_regport_pkg.sv
package i2c_regport_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_ADDR,
        ST_PTR,
        ST_ACK_PTR,
        ST_WR,
        ST_ACK_WR,
        ST_RD,
        ST_ACK_RD,
        ST_SKIP
    } bus_state_e;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_pin,
    input  logic sda_pin,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);

    logic [STAGES-1:0] scl_chain;
    logic [STAGES-1:0] sda_chain;
    logic              scl_prev;
    logic              sda_prev;

    // Bus idles high, so every stage resets to 1.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_chain <= '1;
            sda_chain <= '1;
            scl_prev  <= 1'b1;
            sda_prev  <= 1'b1;
        end else begin
            scl_chain[0] <= scl_pin;
            sda_chain[0] <= sda_pin;
            for (int i = 1; i < STAGES; i++) begin
                scl_chain[i] <= scl_chain[i-1];
                sda_chain[i] <= sda_chain[i-1];
            end
            scl_prev <= scl_chain[STAGES-1];
            sda_prev <= sda_chain[STAGES-1];
        end
    end

    assign scl_lvl  = scl_chain[STAGES-1];
    assign sda_lvl  = sda_chain[STAGES-1];
    assign scl_rise = scl_lvl & ~scl_prev;
    assign scl_fall = ~scl_lvl & scl_prev;
    assign start_ev = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
    assign stop_ev  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;

endmodule

// File: rtl/i2c_lowtime_guard.sv
module i2c_lowtime_guard #(
    parameter int LIMIT = 983
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic scl_lvl,
    output logic expired
);

    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] CAP = CW'(LIMIT);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (scl_lvl) begin
            cnt_q <= '0;
        end else if (tick && cnt_q != CAP) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = (cnt_q == CAP);

    // R9: a high SCL level always restarts the low-time window.
    p_guard_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        scl_lvl |=> !expired);

endmodule

// File: rtl/i2c_regport_fsm.sv
module i2c_regport_fsm
    import i2c_regport_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h68,
    parameter int         ADDR_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_lvl,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_ev,
    input  logic              stop_ev,
    input  logic              tmo,
    input  logic [BYTE_W-1:0] rd_byte,
    output logic              sda_drive,
    output logic              wr_pulse,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [BYTE_W-1:0] wr_byte,
    output logic              snap
);

    localparam logic [ADDR_W-1:0] PTR_MAX = '1;
    localparam logic [3:0]        FULL    = 4'(BYTE_W);

    bus_state_e        state_q, state_d;
    logic [BYTE_W-1:0] shift_q, tx_q, wdata_q;
    logic [3:0]        cnt_q;
    logic [ADDR_W-1:0] ptr_q, wr_addr_q;
    logic              rw_q, nack_q, snap_q, we_q;
    logic              byte_done, addr_hit, abort, rx_phase, ptr_inc;

    assign byte_done = (cnt_q == FULL);
    assign addr_hit  = (shift_q[BYTE_W-1:1] == DEV_ADDR);
    assign abort     = tmo | start_ev | stop_ev;
    assign rx_phase  = (state_q == ST_ADDR) || (state_q == ST_PTR) || (state_q == ST_WR);
    assign ptr_inc   = !abort && scl_fall && byte_done &&
                       ((state_q == ST_WR) || (state_q == ST_RD));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        if (tmo) begin
            state_d = ST_IDLE;
        end else if (start_ev) begin
            state_d = ST_ADDR;
        end else if (stop_ev) begin
            state_d = ST_IDLE;
        end else if (scl_fall) begin
            unique case (state_q)
                ST_IDLE:     state_d = ST_IDLE;
                ST_ADDR:     if (byte_done) state_d = addr_hit ? ST_ACK_ADDR : ST_SKIP;
                ST_ACK_ADDR: state_d = rw_q ? ST_RD : ST_PTR;
                ST_PTR:      if (byte_done) state_d = ST_ACK_PTR;
                ST_ACK_PTR:  state_d = ST_WR;
                ST_WR:       if (byte_done) state_d = ST_ACK_WR;
                ST_ACK_WR:   state_d = ST_WR;
                ST_RD:       if (byte_done) state_d = ST_ACK_RD;
                ST_ACK_RD:   state_d = nack_q ? ST_SKIP : ST_RD;
                ST_SKIP:     state_d = ST_SKIP;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    // Datapath: shifting, pointer, strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q   <= '0;
            tx_q      <= '0;
            wdata_q   <= '0;
            cnt_q     <= '0;
            ptr_q     <= '0;
            wr_addr_q <= '0;
            rw_q      <= 1'b0;
            nack_q    <= 1'b0;
            snap_q    <= 1'b0;
            we_q      <= 1'b0;
        end else begin
            snap_q <= 1'b0;
            we_q   <= 1'b0;
            if (abort) cnt_q <= '0;
            if (start_ev && !tmo) snap_q <= 1'b1;
            if (!abort) begin
                if (scl_rise) begin
                    if (rx_phase && !byte_done) begin
                        shift_q <= {shift_q[BYTE_W-2:0], sda_lvl};
                        cnt_q   <= cnt_q + 1'b1;
                    end
                    if (state_q == ST_RD && !byte_done) cnt_q <= cnt_q + 1'b1;
                    if (state_q == ST_ACK_RD) nack_q <= sda_lvl;
                end
                if (scl_fall) begin
                    unique case (state_q)
                        ST_ADDR: if (byte_done) begin
                            rw_q  <= shift_q[0];
                            cnt_q <= '0;
                        end
                        ST_ACK_ADDR: if (rw_q) tx_q <= rd_byte;
                        ST_PTR: if (byte_done) begin
                            ptr_q <= shift_q[ADDR_W-1:0];
                            cnt_q <= '0;
                        end
                        ST_WR: if (byte_done) begin
                            we_q      <= 1'b1;
                            wr_addr_q <= ptr_q;
                            wdata_q   <= shift_q;
                            cnt_q     <= '0;
                        end
                        ST_RD: begin
                            if (byte_done) cnt_q <= '0;
                            else           tx_q  <= {tx_q[BYTE_W-2:0], 1'b0};
                        end
                        ST_ACK_RD: if (!nack_q) tx_q <= rd_byte;
                        default: ;
                    endcase
                    if (ptr_inc) begin
                        ptr_q <= ptr_q + 1'b1;
                        if (ptr_q == PTR_MAX) snap_q <= 1'b1;
                    end
                end
            end
        end
    end

    // Outputs
    always_comb begin
        sda_drive = 1'b0;
        unique case (state_q)
            ST_ACK_ADDR, ST_ACK_PTR, ST_ACK_WR: sda_drive = 1'b1;
            ST_RD:                              sda_drive = ~tx_q[BYTE_W-1];
            default:                            sda_drive = 1'b0;
        endcase
    end

    assign wr_pulse = we_q;
    assign acc_addr = we_q ? wr_addr_q : ptr_q;
    assign wr_byte  = wdata_q;
    assign snap     = snap_q;

    // R8: SDA is only newly pulled low while SCL is low.
    p_drive_scl_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_drive) |-> !scl_lvl);
    // R3: each register write lasts exactly one cycle.
    p_we_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        we_q |=> !we_q);
    // R5: the snapshot strobe is one cycle wide.
    p_snap_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        snap_q |=> !snap_q);
    // R5: a START is followed by a snapshot.
    p_start_snap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (start_ev && !tmo) |=> snap_q);
    // R4: stepping from the top entry lands on 0 and snapshots.
    p_wrap_snap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_inc && ptr_q == PTR_MAX) |=> (snap_q && ptr_q == '0));
    // R2: the SKIP state neither drives nor writes.
    p_skip_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SKIP) |-> (!sda_drive && !we_q));
    // R10: a write only ever follows a completed data byte.
    p_commit_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
        we_q |-> ($past(state_q) == ST_WR && !$past(abort)));

endmodule

// File: rtl/i2c_regport.sv
module i2c_regport
    import i2c_regport_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR      = 7'h68,
    parameter int         ADDR_W        = 4,
    parameter int         SYNC_STAGES   = 2,
    parameter int         TIMEOUT_TICKS = 983
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_32k,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic              reg_we,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [BYTE_W-1:0] reg_wdata,
    input  logic [BYTE_W-1:0] reg_rdata,
    output logic              shadow_load
);

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_ev, stop_ev, expired;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_pin  (scl_i),
        .sda_pin  (sda_i),
        .scl_lvl  (scl_lvl),
        .sda_lvl  (sda_lvl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    i2c_lowtime_guard #(.LIMIT(TIMEOUT_TICKS)) u_guard (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_32k),
        .scl_lvl (scl_lvl),
        .expired (expired)
    );

    i2c_regport_fsm #(.DEV_ADDR(DEV_ADDR), .ADDR_W(ADDR_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_ev  (start_ev),
        .stop_ev   (stop_ev),
        .tmo       (expired),
        .rd_byte   (reg_rdata),
        .sda_drive (sda_oe),
        .wr_pulse  (reg_we),
        .acc_addr  (reg_addr),
        .wr_byte   (reg_wdata),
        .snap      (shadow_load)
    );

    // R9: an expired low-time window releases SDA on the next cycle.
    p_timeout_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        expired |=> !sda_oe);

endmodule

// File: tb/sim_i2c_regport.sv
module sim_i2c_regport;

    localparam int CLK_PERIOD = 10;
    localparam int Q    = 4;
    localparam int HALF = 12;
    localparam logic [23:0] VEC [6] = '{
        24'h00A53C, 24'h051234, 24'h0EC37E, 24'h0F9966, 24'h0900FF, 24'h035AA5
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_oe, reg_we, shadow_load;
    logic [3:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    logic       sda_bus;
    logic [7:0] regs [16];
    logic [7:0] exp_mem [16];
    int         n_checks = 0, n_fail = 0, snap_cnt = 0, we_cnt = 0, tick_div = 0;
    bit         done = 1'b0;

    assign sda_bus   = sda_m & ~sda_oe;
    assign reg_rdata = regs[reg_addr];

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_regport #(.TIMEOUT_TICKS(16)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_32k(tick), .scl_i(scl_m), .sda_i(sda_bus),
        .sda_oe(sda_oe), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .shadow_load(shadow_load)
    );

    always @(posedge clk) begin
        tick_div <= (tick_div + 1) % 4;
        tick     <= (tick_div == 3);
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) regs[i] <= 8'h80 + 8'(i);
        end else if (reg_we) begin
            regs[reg_addr] <= reg_wdata;
            we_cnt <= we_cnt + 1;
        end
        if (rst_n && shadow_load) snap_cnt <= snap_cnt + 1;
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_start();
        if (!scl_m) begin sda_m = 1'b1; wait_clk(Q); scl_m = 1'b1; wait_clk(HALF); end
        sda_m = 1'b0; wait_clk(HALF); scl_m = 1'b0; wait_clk(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_clk(Q); scl_m = 1'b1; wait_clk(HALF); sda_m = 1'b1; wait_clk(HALF);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; wait_clk(Q); scl_m = 1'b1; wait_clk(HALF); scl_m = 1'b0; wait_clk(Q);
    endtask

    task automatic get_ack(output logic a);
        sda_m = 1'b1; wait_clk(Q); scl_m = 1'b1; wait_clk(HALF/2);
        a = ~sda_bus; wait_clk(HALF/2); scl_m = 1'b0; wait_clk(Q);
    endtask

    task automatic send_byte(input logic [7:0] d, output logic a);
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        get_ack(a);
    endtask

    task automatic recv_byte(input logic m_ack, output logic [7:0] d);
        sda_m = 1'b1;
        for (int i = 0; i < 8; i++) begin
            wait_clk(Q); scl_m = 1'b1; wait_clk(HALF/2);
            d = {d[6:0], sda_bus}; wait_clk(HALF/2); scl_m = 1'b0; wait_clk(Q);
        end
        sda_m = ~m_ack; wait_clk(Q); scl_m = 1'b1; wait_clk(HALF); scl_m = 1'b0; wait_clk(Q);
        sda_m = 1'b1;
    endtask

    task automatic release_bus();
        sda_m = 1'b1; wait_clk(Q); scl_m = 1'b1; wait_clk(HALF);
    endtask

    task automatic read_one(input logic [3:0] p, output logic [7:0] d);
        logic a;
        bus_start(); send_byte(8'hD0, a); send_byte({4'h0, p}, a);
        bus_start(); send_byte(8'hD1, a); recv_byte(1'b0, d); bus_stop();
    endtask

    initial begin
        logic       a;
        logic [7:0] d0, d1, rb;
        int         s0, w0;
        for (int i = 0; i < 16; i++) exp_mem[i] = 8'h80 + 8'(i);
        wait_clk(6);
        // R11: reset state
        check("R11 sda_oe after reset", sda_oe, 0);
        check("R11 reg_we after reset", reg_we, 0);
        check("R11 shadow_load after reset", shadow_load, 0);
        check("R11 pointer after reset", reg_addr, 0);
        rst_n = 1'b1;
        wait_clk(4);

        // Vector table: two-byte write then read back
        for (int v = 0; v < 6; v++) begin
            logic [3:0] p;
            int wraps;
            p = VEC[v][19:16];
            wraps = (p >= 4'hE) ? 1 : 0;
            s0 = snap_cnt;
            bus_start();
            send_byte(8'hD0, a); check("R1 write address ack", a, 1);
            send_byte({4'h0, p}, a); check("R3 pointer byte ack", a, 1);
            send_byte(VEC[v][15:8], a); send_byte(VEC[v][7:0], a);
            bus_stop();
            exp_mem[p] = VEC[v][15:8];
            exp_mem[p + 4'd1] = VEC[v][7:0];
            check("R5 R4 snapshots during write", snap_cnt - s0, 1 + wraps);
            s0 = snap_cnt;
            bus_start(); send_byte(8'hD0, a); send_byte({4'h0, p}, a);
            bus_start(); send_byte(8'hD1, a); check("R1 read address ack", a, 1);
            recv_byte(1'b1, d0); recv_byte(1'b0, d1);
            check("R7 SDA released after NACK", sda_oe, 0);
            bus_stop();
            check("R3 R6 first byte readback", d0, exp_mem[p]);
            check("R4 R6 second byte readback", d1, exp_mem[p + 4'd1]);
            check("R5 snapshots during read", snap_cnt - s0, 2 + wraps);
        end

        // R6: read with no pointer byte continues at pointer 5
        bus_start(); send_byte(8'hD1, a); recv_byte(1'b0, rb);
        check("R6 read from current pointer", rb, exp_mem[5]);
        // R7: no acknowledge for bytes after NACK
        send_byte(8'h00, a); check("R7 silent after NACK", a, 0);
        bus_stop();

        // R2: foreign address
        w0 = we_cnt;
        bus_start(); send_byte(8'hA0, a); check("R2 foreign address not acked", a, 0);
        send_byte(8'h02, a); check("R2 following byte not acked", a, 0);
        send_byte(8'h77, a); bus_stop();
        check("R2 no write on foreign address", we_cnt - w0, 0);

        // R10: repeated START in mid-byte
        w0 = we_cnt;
        bus_start(); send_byte(8'hD0, a); send_byte(8'h08, a);
        for (int i = 7; i >= 4; i--) send_bit(1'b1);
        bus_start(); send_byte(8'hD0, a); check("R10 address after mid-byte START", a, 1);
        bus_stop();
        check("R10 no write on mid-byte START", we_cnt - w0, 0);
        // R10: STOP in mid-byte
        bus_start(); send_byte(8'hD0, a); send_byte(8'h09, a);
        for (int i = 7; i >= 4; i--) send_bit(1'b0);
        bus_stop();
        check("R10 no write on mid-byte STOP", we_cnt - w0, 0);
        read_one(4'h8, rb); check("R10 register 8 untouched", rb, exp_mem[8]);

        // R9: timeout inside a data byte
        w0 = we_cnt;
        bus_start(); send_byte(8'hD0, a); send_byte(8'h0A, a);
        for (int i = 0; i < 5; i++) send_bit(1'b0);
        wait_clk(120);
        check("R9 SDA released after timeout", sda_oe, 0);
        release_bus();
        check("R9 unfinished byte not written", we_cnt - w0, 0);
        read_one(4'hA, rb); check("R9 register A untouched", rb, exp_mem[10]);

        // R9: timeout while the slave holds an acknowledge
        bus_start(); send_byte(8'hD0, a);
        for (int i = 7; i >= 0; i--) send_bit(1'b0);
        check("R1 acknowledge driven on pointer byte", sda_oe, 1);
        wait_clk(120);
        check("R9 acknowledge released on timeout", sda_oe, 0);
        release_bus();

        // R9: high SCL restarts the count
        bus_start(); send_byte(8'hD0, a); send_byte(8'h0C, a);
        wait_clk(48);
        for (int i = 7; i >= 4; i--) send_bit(i[0]);
        wait_clk(48);
        for (int i = 3; i >= 0; i--) send_bit(i[0]);
        get_ack(a);
        check("R9 no timeout when SCL pulses", a, 1);
        bus_stop();
        exp_mem[12] = 8'hAA;
        read_one(4'hC, rb); check("R9 R3 register C written", rb, 8'hAA);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog all requirements actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule